// File: doc/BRIEF.md
# Unpack Transfer Length Calculator

This block sizes one unpack command before any data moves. It takes a 32-bit command word and the current cycle settings: a cycle length (CL), a write length (WL), and a double-buffer base address. From these it produces two results. The first is the number of 32-bit input words the unpack will consume. The second is the destination address in bytes. It also passes the command's unsigned flag through, and it flags a cycle setting that cannot be used.

A request is accepted with a one-cycle `start` pulse, and the results are returned with a one-cycle `done` pulse. When WL is larger than CL (the skipping-write case), the element count is divided by WL. A small sequential divider does this division, handling one dividend bit per cycle. In every other case the result arrives two cycles after `start`. The block does not convert the data, apply any masking, or write to memory.

Top module: `unpack_len_calc`

## Requirements
- R1: The element count is `cmd_word[23:16]`, and a field value of 0 means 256 elements.
- R2: When WL ≤ CL (and the setting is legal), `word_count` = ceil(count × element_bytes / 4).
- R3: When WL > CL, the effective count is CL × floor(count / WL) + min(count mod WL, CL). `word_count` is then ceil(effective × element_bytes / 4).
- R4: The element size is set by two fields of the command word.
  - The width select `cmd_word[25:24]` picks 4, 2 or 1 bytes per component for the values 0, 1 and 2.
  - The component count is `cmd_word[27:26]` + 1.
  - element_bytes = component bytes × component count.
  - Width select 3 is the 5-bit packed format, which is always 2 bytes per element.
- R5: When `cmd_word[15]` is 1, the quadword address is (`cmd_word[9:0]` + `dbuf_base`) modulo 1024.
- R6: When `cmd_word[15]` is 0, the quadword address is `cmd_word[9:0]`, and `dbuf_base` has no effect.
- R7: `byte_addr` equals the quadword address shifted left by 4, so its low 4 bits are zero.
- R8: `unsigned_flag` equals `cmd_word[14]` of the accepted command.
- R9: WL = 0 with CL > 0 is illegal. In that case `illegal` is 1 and `word_count` is 0. WL = 0 with CL = 0 is legal and follows R2.
- R10: `done` is high for exactly one cycle per accepted command.
  - The outputs are valid in the `done` cycle and hold until the next `done`.
  - `done` comes 2 cycles after `start` when no division is needed, and at most CNT_W+4 cycles after `start` when it is.
- R11: A `start` pulse that arrives while a command is still in progress is ignored. It produces no `done` and does not change the results.
- R12: After reset, `done`, `illegal`, `unsigned_flag`, `word_count` and `byte_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accepts a command while the block is idle |
| cmd_word | input | 32 | Unpack command word |
| cyc_cl | input | REG_W | Cycle length setting |
| cyc_wl | input | REG_W | Write length setting |
| dbuf_base | input | ADDR_W | Double-buffer base quadword address |
| done | output | 1 | One-cycle result strobe |
| illegal | output | 1 | Illegal cycle setting seen |
| unsigned_flag | output | 1 | Unsigned flag of the command |
| word_count | output | CNT_W+3 | 32-bit words the unpack will consume |
| byte_addr | output | ADDR_W+4 | Destination byte address |

## Verification
The bench targets the following corner cases, each of which exposes a specific kind of error:

- **Zero count:** A design that forgets the zero-means-256 rule reports a length of zero or a tiny length.
- **Skipping-write remainders:** The bench uses remainders both below and above CL. A design that drops the clamp, or swaps quotient and remainder, reports the wrong word count.
- **Relative address wrap:** The bench adds a base that carries past 10 bits. A design without the modulo produces an out-of-range address.
- **WL = 0:** The bench tries WL = 0 with both zero and nonzero CL. A design that confuses the two either flags a legal setting or sends the divider a zero divisor.
- **Ignored start:** The bench sends a second start during a long division. A design that accepts it emits a second `done` or corrupted results.

// File: rtl/unpack_len_pkg.sv
package unpack_len_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_CALC = 2'd2
  } ulc_state_e;

  localparam int CMD_W      = 32;
  localparam int CNT_LSB    = 16;
  localparam int WSEL_LSB   = 24;
  localparam int CSEL_LSB   = 26;
  localparam int REL_BIT    = 15;
  localparam int UNS_BIT    = 14;
  localparam int EBYTES_W   = 5;
endpackage

// File: rtl/unpack_elem_size.sv
module unpack_elem_size
  import unpack_len_pkg::*;
(
  input  logic [1:0]          wsel,
  input  logic [1:0]          csel,
  output logic [EBYTES_W-1:0] ebytes
);
  logic [EBYTES_W-1:0] comps;

  always_comb begin
    comps = EBYTES_W'(csel) + EBYTES_W'(1);
    case (wsel)
      2'd0:    ebytes = comps << 2;
      2'd1:    ebytes = comps << 1;
      2'd2:    ebytes = comps;
      default: ebytes = EBYTES_W'(2);
    endcase
  end
endmodule

// File: rtl/unpack_addr_gen.sv
module unpack_addr_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              rel,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] qaddr
);
  always_comb begin
    if (rel) qaddr = imm + base;
    else     qaddr = imm;
  end
endmodule

// File: rtl/unpack_seq_div.sv
module unpack_seq_div #(
  parameter int DVD_W = 9,
  parameter int DVS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quot,
  output logic [DVS_W-1:0] rem,
  output logic             fin
);
  localparam int STEP_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  dvd_sh;
  logic [DVS_W-1:0]  dvs_q;
  logic [DVS_W:0]    acc;
  logic [DVS_W:0]    trial;
  logic [STEP_W-1:0] steps;
  logic              running;

  assign trial = {acc[DVS_W-1:0], dvd_sh[DVD_W-1]};
  assign rem   = acc[DVS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_sh  <= '0;
      dvs_q   <= '0;
      acc     <= '0;
      quot    <= '0;
      steps   <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        dvd_sh  <= dividend;
        dvs_q   <= divisor;
        acc     <= '0;
        quot    <= '0;
        steps   <= STEP_W'(DVD_W);
        running <= 1'b1;
      end else if (running) begin
        if (trial >= {1'b0, dvs_q}) begin
          acc  <= trial - {1'b0, dvs_q};
          quot <= {quot[DVD_W-2:0], 1'b1};
        end else begin
          acc  <= trial;
          quot <= {quot[DVD_W-2:0], 1'b0};
        end
        dvd_sh <= dvd_sh << 1;
        steps  <= steps - STEP_W'(1);
        if (steps == STEP_W'(1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/unpack_len_calc.sv
module unpack_len_calc
  import unpack_len_pkg::*;
#(
  parameter  int CNT_W  = 8,
  parameter  int ADDR_W = 10,
  parameter  int REG_W  = 8,
  localparam int WC_W   = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [REG_W-1:0]  cyc_cl,
  input  logic [REG_W-1:0]  cyc_wl,
  input  logic [ADDR_W-1:0] dbuf_base,
  output logic              done,
  output logic              illegal,
  output logic              unsigned_flag,
  output logic [WC_W-1:0]   word_count,
  output logic [ADDR_W+3:0] byte_addr
);
  localparam int DVD_W   = CNT_W + 1;
  localparam int PROD_W  = REG_W + DVD_W;
  localparam int BYTES_W = DVD_W + EBYTES_W;

  ulc_state_e          state;
  logic [DVD_W-1:0]    cnt_full, cnt_q;
  logic [REG_W-1:0]    cl_q;
  logic [EBYTES_W-1:0] eb_now, eb_q;
  logic [ADDR_W-1:0]   qaddr_now, qaddr_q;
  logic                uns_q, ill_q, skip_q;
  logic                ill_now, skip_now, accept, div_start;
  logic [DVD_W-1:0]    div_q;
  logic [REG_W-1:0]    div_r;
  logic                div_fin;
  logic [REG_W-1:0]    tail;
  logic [PROD_W-1:0]   eff_wide;
  logic [DVD_W-1:0]    eff;
  logic [BYTES_W-1:0]  total_bytes;
  logic [WC_W-1:0]     wc_next;

  unpack_elem_size u_esize (
    .wsel   (cmd_word[WSEL_LSB +: 2]),
    .csel   (cmd_word[CSEL_LSB +: 2]),
    .ebytes (eb_now)
  );

  unpack_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .rel   (cmd_word[REL_BIT]),
    .imm   (cmd_word[ADDR_W-1:0]),
    .base  (dbuf_base),
    .qaddr (qaddr_now)
  );

  unpack_seq_div #(.DVD_W(DVD_W), .DVS_W(REG_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (cnt_full),
    .divisor  (cyc_wl),
    .quot     (div_q),
    .rem      (div_r),
    .fin      (div_fin)
  );

  always_comb begin
    if (cmd_word[CNT_LSB +: CNT_W] == '0) cnt_full = {1'b1, {CNT_W{1'b0}}};
    else                                  cnt_full = {1'b0, cmd_word[CNT_LSB +: CNT_W]};
    ill_now   = (cyc_wl == '0) && (cyc_cl != '0);
    skip_now  = (cyc_wl > cyc_cl);
    accept    = (state == ST_IDLE) && start;
    div_start = accept && skip_now && !ill_now;
  end

  always_comb begin
    tail        = (div_r < cl_q) ? div_r : cl_q;
    eff_wide    = PROD_W'(cl_q) * PROD_W'(div_q) + PROD_W'(tail);
    eff         = skip_q ? eff_wide[DVD_W-1:0] : cnt_q;
    total_bytes = BYTES_W'(eff) * BYTES_W'(eb_q);
    wc_next     = ill_q ? '0 : WC_W'((total_bytes + BYTES_W'(3)) >> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cnt_q         <= '0;
      cl_q          <= '0;
      eb_q          <= '0;
      qaddr_q       <= '0;
      uns_q         <= 1'b0;
      ill_q         <= 1'b0;
      skip_q        <= 1'b0;
      done          <= 1'b0;
      illegal       <= 1'b0;
      unsigned_flag <= 1'b0;
      word_count    <= '0;
      byte_addr     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cnt_q   <= cnt_full;
            cl_q    <= cyc_cl;
            eb_q    <= eb_now;
            qaddr_q <= qaddr_now;
            uns_q   <= cmd_word[UNS_BIT];
            ill_q   <= ill_now;
            skip_q  <= skip_now && !ill_now;
            state   <= div_start ? ST_DIV : ST_CALC;
          end
        end
        ST_DIV: begin
          if (div_fin) state <= ST_CALC;
        end
        ST_CALC: begin
          done          <= 1'b1;
          illegal       <= ill_q;
          unsigned_flag <= uns_q;
          word_count    <= wc_next;
          byte_addr     <= {qaddr_q, 4'b0000};
          state         <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unpack_len_calc_chk.sv
module unpack_len_calc_chk #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 10,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              illegal,
  input logic [CNT_W+2:0]  word_count,
  input logic [ADDR_W+3:0] byte_addr
);
  localparam int LAT_MAX = CNT_W + 4;
  localparam int LAT_W   = $clog2(LAT_MAX + 2) + 1;

  logic             pend;
  logic [LAT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (done) begin
        pend     <= start;
        wait_cnt <= '0;
      end else if (!pend && start) begin
        pend     <= 1'b1;
        wait_cnt <= '0;
      end else if (pend) begin
        wait_cnt <= wait_cnt + LAT_W'(1);
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_start_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> pend);
  assert_latency_bound_R10: assert property (@(posedge clk) disable iff (rst)
    pend |-> (wait_cnt <= LAT_W'(LAT_MAX)));
  assert_illegal_no_words_R9: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> (word_count == '0));
  assert_addr_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (byte_addr[3:0] == 4'b0000));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (word_count <= (CNT_W+3)'(1 << (CNT_W + 2))));
endmodule

bind unpack_len_calc unpack_len_calc_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .done       (done),
  .illegal    (illegal),
  .word_count (word_count),
  .byte_addr  (byte_addr)
);

// File: tb/unpack_len_calc_test.sv
module unpack_len_calc_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] cmd_word;
  logic [7:0]  cyc_cl, cyc_wl;
  logic [9:0]  dbuf_base;
  logic        done, illegal, unsigned_flag;
  logic [10:0] word_count;
  logic [13:0] byte_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  unpack_len_calc uut (
    .clk(clk), .rst(rst), .start(start), .cmd_word(cmd_word),
    .cyc_cl(cyc_cl), .cyc_wl(cyc_wl), .dbuf_base(dbuf_base),
    .done(done), .illegal(illegal), .unsigned_flag(unsigned_flag),
    .word_count(word_count), .byte_addr(byte_addr)
  );

  function automatic int exp_eb(logic [31:0] c);
    int k = int'(c[27:26]) + 1;
    case (c[25:24])
      2'd0:    return 4 * k;
      2'd1:    return 2 * k;
      2'd2:    return k;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_words(logic [31:0] c, int cl, int wl);
    int n;
    int r;
    if (wl == 0 && cl > 0) return 0;
    n = int'(c[23:16]);
    if (n == 0) n = 256;
    if (wl > cl) begin
      r = n % wl;
      n = cl * (n / wl) + ((r < cl) ? r : cl);
    end
    return (n * exp_eb(c) + 3) / 4;
  endfunction

  function automatic int exp_addr(logic [31:0] c, int base);
    int a = int'(c[9:0]);
    if (c[15]) a = (a + base) % 1024;
    return a * 16;
  endfunction

  function automatic logic [31:0] mk(int cnt, int w, int k, bit rel, bit uns, int imm);
    logic [31:0] c;
    c = '0;
    c[31:24] = 8'h60 | 8'(k << 2) | 8'(w);
    c[23:16] = 8'(cnt);
    c[15] = rel;
    c[14] = uns;
    c[9:0] = 10'(imm);
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_one(logic [31:0] c, int cl, int wl, int base, string req);
    int lat;
    int ew, ea;
    @(negedge clk);
    cmd_word = c; cyc_cl = 8'(cl); cyc_wl = 8'(wl); dbuf_base = 10'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    ew = exp_words(c, cl, wl);
    ea = exp_addr(c, base);
    chk(done === 1'b1, {req, " done seen (R10)"}, int'(done), 1);
    chk(lat <= 12, {req, " latency (R10)"}, lat, 12);
    if (wl <= cl) chk(lat == 2, {req, " short latency (R10)"}, lat, 2);
    chk(word_count == 11'(ew), {req, " word_count"}, int'(word_count), ew);
    chk(byte_addr == 14'(ea), {req, " byte_addr (R7)"}, int'(byte_addr), ea);
    chk(unsigned_flag == c[14], {req, " unsigned (R8)"}, int'(unsigned_flag), int'(c[14]));
    chk(illegal == (wl == 0 && cl > 0), {req, " illegal (R9)"}, int'(illegal), int'(wl == 0 && cl > 0));
    @(negedge clk);
    chk(done == 1'b0, {req, " done one cycle (R10)"}, int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; cmd_word = '0; cyc_cl = '0; cyc_wl = '0; dbuf_base = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && illegal == 0 && unsigned_flag == 0 && word_count == 0 && byte_addr == 0,
        "R12 reset state", int'(word_count), 0);

    run_one(mk(0, 0, 3, 0, 0, 5), 4, 4, 0, "R1 zero count");
    run_one(mk(0, 2, 0, 0, 0, 1), 1, 2, 0, "R1 zero count skip");
    run_one(mk(20, 1, 1, 0, 0, 9), 4, 2, 0, "R2 wl<cl");
    run_one(mk(10, 2, 0, 0, 0, 3), 1, 4, 0, "R3 rem clamp");
    run_one(mk(7, 1, 2, 0, 0, 3), 2, 3, 0, "R3 rem below cl");
    run_one(mk(255, 0, 0, 0, 0, 0), 0, 255, 0, "R3 cl zero");
    run_one(mk(3, 3, 3, 0, 0, 0), 1, 1, 0, "R4 packed 5-bit");
    run_one(mk(5, 3, 0, 0, 0, 0), 1, 1, 0, "R4 packed other csel");
    run_one(mk(9, 2, 2, 0, 0, 0), 1, 1, 0, "R4 byte x3");
    run_one(mk(4, 0, 0, 1, 0, 10'h3F0), 1, 1, 10'h020, "R5 wrap");
    run_one(mk(4, 0, 0, 0, 0, 10'h123), 1, 1, 10'h2AA, "R6 base ignored");
    run_one(mk(4, 0, 0, 0, 1, 7), 1, 1, 0, "R8 unsigned set");
    run_one(mk(4, 0, 0, 0, 0, 7), 3, 0, 0, "R9 wl zero");
    run_one(mk(4, 0, 0, 0, 0, 7), 0, 0, 0, "R9 both zero legal");

    // R11: a second start during a long division must be ignored
    begin
      logic [31:0] c1;
      int n_done;
      c1 = mk(200, 0, 1, 0, 0, 17);
      @(negedge clk);
      cmd_word = c1; cyc_cl = 8'd3; cyc_wl = 8'd7; dbuf_base = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      cmd_word = mk(1, 2, 0, 0, 1, 900); cyc_cl = 8'd1; cyc_wl = 8'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cmd_word = c1; cyc_cl = 8'd3; cyc_wl = 8'd7;
      n_done = 0;
      for (int i = 0; i < 30; i++) begin
        if (done) begin
          n_done++;
          chk(word_count == 11'(exp_words(c1, 3, 7)), "R11 result kept", int'(word_count), exp_words(c1, 3, 7));
          chk(byte_addr == 14'(exp_addr(c1, 0)), "R11 addr kept", int'(byte_addr), exp_addr(c1, 0));
        end
        @(negedge clk);
      end
      chk(n_done == 1, "R11 single done", n_done, 1);
    end

    for (int i = 0; i < 300; i++) begin
      logic [31:0] c;
      int cl, wl;
      c = $urandom;
      cl = (i % 2 == 0) ? int'($urandom_range(0, 8)) : int'($urandom_range(0, 255));
      wl = (i % 3 == 0) ? int'($urandom_range(0, 8)) : int'($urandom_range(0, 255));
      run_one(c, cl, wl, int'($urandom_range(0, 1023)), "R3 random");
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule